// File: doc/BRIEF.md
# Register-Mapped Single-Byte SPI Master

This block is a full-duplex SPI master that software controls through four 32-bit registers on a simple register bus. It uses one serial output line and one serial input line. A write to the data-out register sends one byte and receives one byte at the same time. The received byte is then read from the data-in register. A ready flag in the control register shows when the shift engine is idle.

Software sets the serial clock divider, the clock polarity and the clock phase in the configuration register. It also holds one chip-select enable bit per slave in the control register. A chip select stays asserted across any number of bytes until software clears its bit. The configuration register also has a self-clearing flush command, which empties the data-in register. The transfer-length bit and the queue-enable bit are fixed at zero, so the block always works one byte at a time.

Top module: `spi_legacy_master`

## Requirements
- R1: After reset all chip-select outputs are high (deasserted), `spi_sck` and `spi_mosi` are low, the control register reads 0x0000_0002 (ready set), and the configuration and data-in registers read 0.
- R2: Reads are decoded from `bus_addr` with no wait state. Control is at 0x0, configuration at 0x4, data-out at 0x8 (always reads 0) and data-in at 0xC. Any other address reads 0.
- R3: Control bit 16+n drives slave n. `spi_cs_n[n]` is low exactly while that bit is set. The bit changes only when software writes the control register, so a chip select holds across exchanges.
- R4: A write to data-out while the ready flag (control bit 1) is 1 starts an exchange. The ready flag then reads 0 for exactly 8·D clock cycles, where D is the effective divider.
- R5: The effective divider D is configuration bits [4:0], except that the values 0 and 1 give D = 2. Each bit takes D clock cycles: a first half of floor(D/2) cycles, then a second half of the remaining cycles.
- R6: When idle, `spi_sck` equals CPOL (configuration bit 7). During a bit, `spi_sck` equals CPOL xor CPHA in the first half and the inverse of that in the second half. CPHA is configuration bit 6.
- R7: `spi_mosi` sends bits [7:0] of the written byte, most significant bit first. Each bit is held for its whole bit period. The line is low when idle.
- R8: `spi_miso` is sampled at the clock edge that ends the first half of each bit, most significant bit first. Once the ready flag is back to 1, data-in bits [7:0] hold the byte received in the last exchange.
- R9: A write to data-out while the ready flag is 0 is ignored. The running exchange, its timing and its received byte are not affected.
- R10: Writing 1 to configuration bit 9 clears data-in. Bit 9 then reads 1 for FLUSH_CYCLES clock cycles and returns to 0 by itself.
- R11: Configuration bit 5 (transfer length) and bit 17 (queue enable) always read 0. Writing 1 to them has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 for a write when bus_sel is high |
| bus_addr | input | 4 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the slaves |
| spi_miso | input | 1 | Serial data from the selected slave |
| spi_cs_n | output | NUM_CS | Active-low chip selects, one per slave |

## Verification
The hardest case to reach from the ports is a data-out write that arrives while an exchange is in flight. The bench starts a byte at a mid-range divider, waits a few cycles, and then writes a different byte. The cycle-level model must then find the original bit stream, the original ready duration and the original received byte. A flush that overlaps the end of a byte is avoided on purpose. The bench instead checks flush timing and the clearing of data-in after a completed exchange has left a known byte there.

// File: rtl/spi_legacy_master.sv
module spi_legacy_master #(
  parameter int NUM_CS       = 4,
  parameter int DIV_W        = 5,
  parameter int FLUSH_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [3:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              spi_sck,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic [NUM_CS-1:0] spi_cs_n
);
  localparam int FL_W = $clog2(FLUSH_CYCLES + 1);

  logic [NUM_CS-1:0] cs_en;
  logic [DIV_W-1:0]  presc;
  logic              cpha, cpol;
  logic [FL_W-1:0]   flush_cnt;
  logic              busy;
  logic [DIV_W-1:0]  cnt;
  logic [2:0]        bitn;
  logic [7:0]        tx, rx, din;

  wire [DIV_W-1:0] div  = (presc < DIV_W'(2)) ? DIV_W'(2) : presc;
  wire [DIV_W-1:0] half = div >> 1;
  wire wr_ctrl   = bus_sel & bus_we & (bus_addr == 4'h0);
  wire wr_cfg    = bus_sel & bus_we & (bus_addr == 4'h4);
  wire wr_dout   = bus_sel & bus_we & (bus_addr == 4'h8);
  wire start     = wr_dout & ~busy;
  wire last_tick = cnt == div - DIV_W'(1);
  wire sample    = cnt == half - DIV_W'(1);
  wire lead_lvl  = cpol ^ cpha;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_en     <= '0;
      presc     <= '0;
      cpha      <= 1'b0;
      cpol      <= 1'b0;
      flush_cnt <= '0;
      busy      <= 1'b0;
      cnt       <= '0;
      bitn      <= '0;
      tx        <= '0;
      rx        <= '0;
      din       <= '0;
    end else begin
      if (busy) begin
        if (sample) rx <= {rx[6:0], spi_miso};
        if (last_tick) begin
          cnt <= '0;
          if (bitn == 3'd7) begin
            busy <= 1'b0;
            din  <= rx;
          end else begin
            bitn <= bitn + 3'd1;
            tx   <= {tx[6:0], 1'b0};
          end
        end else begin
          cnt <= cnt + DIV_W'(1);
        end
      end
      if (start) begin
        busy <= 1'b1;
        cnt  <= '0;
        bitn <= '0;
        tx   <= bus_wdata[7:0];
        rx   <= '0;
      end
      if (flush_cnt != '0) flush_cnt <= flush_cnt - FL_W'(1);
      if (wr_cfg) begin
        presc <= bus_wdata[DIV_W-1:0];
        cpha  <= bus_wdata[6];
        cpol  <= bus_wdata[7];
        if (bus_wdata[9]) begin
          flush_cnt <= FL_W'(FLUSH_CYCLES);
          din       <= '0;
        end
      end
      if (wr_ctrl) cs_en <= bus_wdata[16 +: NUM_CS];
    end
  end

  assign spi_sck  = busy ? ((cnt < half) ? lead_lvl : ~lead_lvl) : cpol;
  assign spi_mosi = busy & tx[7];
  assign spi_cs_n = ~cs_en;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      4'h0: begin
        bus_rdata[16 +: NUM_CS] = cs_en;
        bus_rdata[1]            = ~busy;
      end
      4'h4: begin
        bus_rdata[DIV_W-1:0] = presc;
        bus_rdata[6]         = cpha;
        bus_rdata[7]         = cpol;
        bus_rdata[9]         = flush_cnt != '0;
      end
      4'hC: bus_rdata[7:0] = din;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/spi_legacy_master_chk.sv
module spi_legacy_master_chk #(
  parameter int NUM_CS = 4,
  parameter int FL_W   = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [3:0]        bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              busy,
  input logic              cpol,
  input logic              spi_sck,
  input logic              spi_mosi,
  input logic [NUM_CS-1:0] spi_cs_n,
  input logic [FL_W-1:0]   flush_cnt
);
  p_sck_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> spi_sck == cpol);

  p_mosi_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !spi_mosi);

  p_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && bus_addr == 4'h8 && !busy) |=> busy);

  p_cs_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_we && bus_addr == 4'h0) |=> $stable(spi_cs_n));

  p_flush_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && bus_addr == 4'h4 && bus_wdata[9]) |=> flush_cnt != '0);
endmodule

bind spi_legacy_master spi_legacy_master_chk #(.NUM_CS(NUM_CS), .FL_W(FL_W)) u_chk (.*);

// File: tb/spi_legacy_master_test.sv
`timescale 1ns/100ps
module spi_legacy_master_test;
  localparam int NCS = 4;
  localparam int FLC = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_we = 1'b0;
  logic [3:0] bus_addr = 4'h0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic spi_sck, spi_mosi, spi_miso = 1'b1;
  logic [NCS-1:0] spi_cs_n;

  int total = 0, bad = 0;

  spi_legacy_master #(.NUM_CS(NCS), .DIV_W(5), .FLUSH_CYCLES(FLC)) uut (.*);

  always #2 clk = ~clk;

  int m_cs = 0, m_presc = 0, m_cpha = 0, m_cpol = 0, m_fl = 0;
  int m_busy = 0, m_t = 0, m_tx = 0, m_rx = 0, m_din = 0;
  int slave_byte = 0;

  function automatic int eff_div(int p);
    return (p < 2) ? 2 : p;
  endfunction

  function automatic int model_read(int a);
    case (a)
      0: return (m_cs << 16) | ((m_busy == 0) << 1);
      4: return m_presc | (m_cpha << 6) | (m_cpol << 7) | ((m_fl > 0) << 9);
      12: return m_din;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cs = 0; m_presc = 0; m_cpha = 0; m_cpol = 0; m_fl = 0;
      m_busy = 0; m_t = 0; m_tx = 0; m_rx = 0; m_din = 0;
    end else begin
      int d, was_busy;
      d = eff_div(m_presc);
      was_busy = m_busy;
      if (m_busy) begin
        if (m_t % d == d / 2 - 1) m_rx = ((m_rx << 1) | int'(spi_miso)) & 8'hFF;
        m_t++;
        if (m_t == 8 * d) begin m_busy = 0; m_din = m_rx; end
      end
      if (m_fl > 0) m_fl--;
      if (bus_sel && bus_we) begin
        case (bus_addr)
          4'h0: m_cs = int'(bus_wdata[16 +: NCS]);
          4'h4: begin
            m_presc = int'(bus_wdata[4:0]);
            m_cpha = int'(bus_wdata[6]);
            m_cpol = int'(bus_wdata[7]);
            if (bus_wdata[9]) begin m_fl = FLC; m_din = 0; end
          end
          4'h8: if (!was_busy) begin
            m_busy = 1; m_t = 0; m_tx = int'(bus_wdata[7:0]); m_rx = 0;
          end
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      int d, esck, emosi;
      d = eff_div(m_presc);
      if (m_busy) begin
        esck = ((m_t % d) < d / 2) ? (m_cpol ^ m_cpha) : 1 - (m_cpol ^ m_cpha);
        emosi = (m_tx >> (7 - m_t / d)) & 1;
      end else begin
        esck = m_cpol;
        emosi = 0;
      end
      chk("R5 R6 sck cycle", 32'(spi_sck), 32'(esck));
      chk("R7 mosi cycle", 32'(spi_mosi), 32'(emosi));
      chk("R3 cs_n cycle", 32'(spi_cs_n), 32'(~m_cs & 4'hF));
      chk("R2 rdata cycle", bus_rdata, 32'(model_read(int'(bus_addr))));
      spi_miso = m_busy ? slave_byte[7 - m_t / d] : 1'b1;
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] v);
    @(posedge clk); #1;
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = v;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    @(posedge clk); #1;
    bus_addr = a;
    #0.5 v = bus_rdata;
  endtask

  task automatic xfer(input int txb, input int rxb, input int p, input int ph, input int pl);
    logic [31:0] v;
    int low;
    wr(4'h4, 32'(p | (ph << 6) | (pl << 7)));
    slave_byte = rxb;
    wr(4'h8, 32'(txb));
    bus_addr = 4'h0;
    low = 0;
    forever begin
      @(negedge clk);
      if (bus_rdata[1]) break;
      low++;
    end
    chk("R4 R5 ready low cycles", 32'(low), 32'(8 * eff_div(p)));
    rd(4'hC, v);
    chk("R8 din byte", v, 32'(rxb));
  endtask

  initial begin
    #(4 * 150000);
    bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    rd(4'h0, v); chk("R1 ctrl reset", v, 32'h2);
    rd(4'h4, v); chk("R1 cfg reset", v, 32'h0);
    rd(4'hC, v); chk("R1 din reset", v, 32'h0);
    rd(4'h8, v); chk("R2 dout reads zero", v, 32'h0);
    chk("R1 cs_n reset", 32'(spi_cs_n), 32'hF);
    chk("R1 sck reset", 32'(spi_sck), 32'h0);

    wr(4'h4, 32'h0002_0023);
    rd(4'h4, v); chk("R11 len and queue bits read 0", v, 32'h3);

    wr(4'h0, 32'h0005_0000);
    rd(4'h0, v); chk("R3 ctrl cs bits", v, 32'h0005_0002);
    chk("R3 cs_n asserted", 32'(spi_cs_n), 32'hA);

    xfer(8'hA5, 8'h3C, 0, 0, 0);
    xfer(8'h5A, 8'hC3, 1, 1, 0);
    xfer(8'h81, 8'h18, 3, 1, 0);
    xfer(8'h0F, 8'hF0, 5, 0, 1);
    xfer(8'hE7, 8'h99, 31, 1, 1);
    xfer(8'h01, 8'h80, 2, 0, 0);
    chk("R3 cs_n held across bytes", 32'(spi_cs_n), 32'hA);

    wr(4'h4, 32'h4);
    slave_byte = 8'h7E;
    wr(4'h8, 32'h81);
    repeat (5) @(posedge clk);
    wr(4'h8, 32'hFF);
    while (m_busy) @(posedge clk);
    rd(4'hC, v); chk("R9 busy write ignored din", v, 32'h7E);

    wr(4'h4, 32'h204);
    rd(4'h4, v); chk("R10 flush reads 1", v[9], 1'b1);
    rd(4'hC, v); chk("R10 flush clears din", v, 32'h0);
    repeat (FLC + 1) @(posedge clk);
    rd(4'h4, v); chk("R10 flush self clears", v, 32'h4);

    wr(4'h0, 32'h0);
    chk("R3 cs_n released", 32'(spi_cs_n), 32'hF);
    repeat (4) @(posedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule